// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Controller

This block lets several peripheral stages share one interrupt request line towards a processor. A stage signals an event with a one-cycle raise pulse, which latches a pending flag. The shared request output goes high while any pending stage outranks every level now being served. The processor answers with a one-cycle acknowledge. The acknowledge enters the chain at stage 0 and moves through the stages in index order. A stage that is not eligible passes it on in the same cycle. The first eligible stage absorbs it and places its own vector on the vector bus. When no stage is eligible, an all-ones spurious vector is returned.

The unit also supports nested service. Stage 0 has the highest priority. Each grant sets the in-service bit of that level. While a level is in service, requests from the same level and from lower levels are held back from the shared line. A request from a higher level still gets through and can preempt the handler. An end-of-interrupt pulse clears the highest-priority in-service bit.

The vector output is a single-cycle pulse qualified by `vec_valid`, which equals the acknowledge. It has no ready input and no back-pressure, because the processor samples the vector in the acknowledge cycle itself.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset no stage is pending, no level is in service, `int_req` is low and `vec_valid` is low.
- R2: A raise pulse on stage i sets its pending flag. `int_req` is high from the next cycle on, provided no level with index ≤ i is in service.
- R3: While `int_ack` is high, `vec_valid` is high in that same cycle. `vec_data` carries the vector of the lowest-index eligible pending stage. Stage i's vector is bits [8i+7:8i] of `dev_vec`.
- R4: The stage granted in an acknowledge cycle has its pending flag cleared at the end of that cycle.
- R5: A grant to stage i marks level i in service. From then on, pending stages with index ≥ i do not drive `int_req` and cannot be granted.
- R6: A pending stage with an index below every in-service level drives `int_req` and is granted on acknowledge. This is nested preemption.
- R7: An `eoi` pulse clears only the lowest-index in-service bit. An `eoi` with nothing in service has no effect.
- R8: An acknowledge with no eligible pending stage returns `vec_data` = 0xFF with `vec_valid` high. It changes no pending or in-service state.
- R9: A raise pulse on a stage in the same cycle as its grant leaves that stage pending.
- R10: While `int_ack` is low, `vec_valid` is low and `vec_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_raise | input | N | Per-stage one-cycle event pulse |
| dev_vec | input | N*8 | Per-stage vector, stage i at bits [8i+7:8i] |
| int_ack | input | 1 | One-cycle acknowledge from the processor |
| eoi | input | 1 | One-cycle end-of-interrupt pulse |
| int_req | output | 1 | Shared interrupt request line |
| vec_valid | output | 1 | Vector qualifier, high during acknowledge |
| vec_data | output | 8 | Granted or spurious vector |

## Verification
The assertions take `int_ack` and `eoi` to be single-cycle pulses. They also take `dev_vec` to be stable around an acknowledge. The bench drives every input on the falling edge. Acknowledge and end-of-interrupt only ever appear as isolated one-cycle pulses, and the vectors are held constant for the whole run. Spurious acknowledges are issued on purpose only while `int_req` is low, which is where the spurious-vector check applies.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int MAX_STAGES = 32;

  // isolate the least significant set bit
  function automatic logic [MAX_STAGES-1:0] lsb_isolate(input logic [MAX_STAGES-1:0] x);
    return x & (~x + 1'b1);
  endfunction
endpackage

// File: rtl/irq_stage.sv
module irq_stage #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise,
  input  logic             allow,
  input  logic             pass_in,
  input  logic [VEC_W-1:0] vec_in,
  output logic             pass_out,
  output logic             grant,
  output logic             elig,
  output logic [VEC_W-1:0] vec_out
);
  logic pending;

  assign elig     = pending & allow;
  assign grant    = pass_in & elig;
  assign pass_out = pass_in & ~elig;
  assign vec_out  = grant ? vec_in : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= (pending & ~grant) | raise;
  end

  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !raise) |=> !pending);

  // R9
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> pending);
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_chain_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] grant,
  input  logic         eoi,
  output logic [N-1:0] allow
);
  localparam int PADW = MAX_STAGES - N;

  logic [N-1:0] isr;
  logic [N-1:0] top_bit;
  logic [MAX_STAGES-1:0] iso;

  assign iso     = lsb_isolate({{PADW{1'b0}}, isr});
  assign top_bit = iso[N-1:0];

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      seen     = seen | isr[i];
      allow[i] = ~seen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~(eoi ? top_bit : '0)) | grant;
  end

  // R5
  isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((isr & $past(grant)) == $past(grant)));

  // R7
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && grant == '0 && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R7
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && grant == '0 && isr == '0) |=> (isr == '0));
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl #(
  parameter int N     = 4,
  parameter int VEC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       dev_raise,
  input  logic [N*VEC_W-1:0] dev_vec,
  input  logic               int_ack,
  input  logic               eoi,
  output logic               int_req,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_data
);
  logic [N:0]       pass;
  logic [N-1:0]     grant;
  logic [N-1:0]     elig;
  logic [N-1:0]     allow;
  logic [VEC_W-1:0] vec_part [N];
  logic [VEC_W-1:0] vec_any;

  assign pass[0] = int_ack;

  for (genvar i = 0; i < N; i++) begin : g_stage
    irq_stage #(.VEC_W(VEC_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .raise   (dev_raise[i]),
      .allow   (allow[i]),
      .pass_in (pass[i]),
      .vec_in  (dev_vec[i*VEC_W +: VEC_W]),
      .pass_out(pass[i+1]),
      .grant   (grant[i]),
      .elig    (elig[i]),
      .vec_out (vec_part[i])
    );
  end

  irq_inservice #(.N(N)) u_isr (
    .clk  (clk),
    .rst_n(rst_n),
    .grant(grant),
    .eoi  (eoi),
    .allow(allow)
  );

  always_comb begin
    vec_any = '0;
    for (int i = 0; i < N; i++) vec_any = vec_any | vec_part[i];
  end

  assign int_req   = |elig;
  assign vec_valid = int_ack;
  assign vec_data  = !int_ack ? '0 : (pass[N] ? '1 : vec_any);

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req) |-> (vec_data == '1 && grant == '0));

  // R3
  ack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req) |-> (grant != '0));
endmodule

// File: tb/irq_chain_ctrl_bench.sv
module irq_chain_ctrl_bench;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dev_raise = '0;
  logic [N*W-1:0] dev_vec = {8'h40, 8'h30, 8'h20, 8'h10};
  logic         int_ack = 1'b0;
  logic         eoi = 1'b0;
  logic         int_req, vec_valid;
  logic [W-1:0] vec_data;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_chain_ctrl #(.N(N), .VEC_W(W)) u_irq_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_raise(dev_raise), .dev_vec(dev_vec),
    .int_ack(int_ack), .eoi(eoi), .int_req(int_req),
    .vec_valid(vec_valid), .vec_data(vec_data)
  );

  // {req id, raise[3:0], {ack,eoi,exp_req,exp_valid}, exp_vec}
  localparam logic [19:0] TBL [24] = '{
    20'h24000, // R2 raise stage 2
    20'h20200, // R2 request seen
    20'h30B30, // R3 ack -> stage 2 vector
    20'h48000, // R4 raise stage 3, stage 2 cleared
    20'h50000, // R5 stage 3 masked by level 2
    20'h21000, // R2 raise stage 0
    20'h60200, // R6 higher level requests
    20'h60B10, // R6 nested grant stage 0
    20'h70400, // R7 eoi clears level 0
    20'h70400, // R7 eoi clears level 2
    20'h70200, // R7 stage 3 unmasked
    20'h30B40, // R3 ack -> stage 3
    20'h809FF, // R8 spurious ack
    20'h70400, // R7 eoi clears level 3
    20'h33000, // R2 raise stages 0 and 1
    20'h30B10, // R3 chain order picks stage 0
    20'h50400, // R5 stage 1 masked until eoi
    20'h70200, // R7 stage 1 unmasked
    20'h92B20, // R9 grant and raise together
    20'h90400, // R9 eoi
    20'h90200, // R9 stage 1 still pending
    20'h40B20, // R4 second grant of stage 1
    20'h70400, // R7 eoi
    20'hA0000  // R10 idle outputs
  };

  task automatic check(input int rq, input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL R0 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(1, {7'd0, int_req}, 8'h00, "int_req in reset");
    check(1, {7'd0, vec_valid}, 8'h00, "vec_valid in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(1, {7'd0, int_req}, 8'h00, "int_req after reset");

    for (int s = 0; s < 24; s++) begin
      @(negedge clk);
      dev_raise = TBL[s][15:12];
      int_ack   = TBL[s][11];
      eoi       = TBL[s][10];
      #1;
      check(int'(TBL[s][19:16]), {7'd0, int_req}, {7'd0, TBL[s][9]}, "int_req");
      check(int'(TBL[s][19:16]), {7'd0, vec_valid}, {7'd0, TBL[s][8]}, "vec_valid");
      check(int'(TBL[s][19:16]), vec_data, TBL[s][7:0], "vec_data");
    end

    // R7 eoi with nothing in service, then level 3 still reachable
    @(negedge clk); dev_raise = '0; int_ack = 0; eoi = 1;
    @(negedge clk); eoi = 0; dev_raise = 4'b1000;
    @(negedge clk); dev_raise = '0; int_ack = 1; #1;
    check(7, vec_data, 8'h40, "grant after idle eoi");
    @(negedge clk); int_ack = 0; eoi = 1;
    @(negedge clk); eoi = 0;

    // R1 reset clears pending state
    dev_raise = 4'b0001;
    @(negedge clk); dev_raise = '0; #1;
    check(2, {7'd0, int_req}, 8'h01, "int_req before reset");
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    check(1, {7'd0, int_req}, 8'h00, "int_req during reset");
    rst_n = 1'b1;
    @(negedge clk); int_ack = 1; #1;
    check(1, vec_data, 8'hFF, "ack after reset is spurious");
    check(8, {7'd0, vec_valid}, 8'h01, "spurious valid");
    @(negedge clk); int_ack = 0; #1;
    check(10, vec_data, 8'h00, "idle vec_data");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule